// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Per-Character Error Tags

This block turns an asynchronous serial line into parallel characters. A one-cycle enable that runs at sixteen times the bit rate drives the sampling. A falling edge on an idle line starts a character. The start bit must still be low at its mid-bit sample; if it is not, the edge is treated as noise and dropped. Each data bit and the parity bit is decided by a two-of-three vote on the samples around the middle of the bit. Before the first bit, software-facing logic sets the data length (5 to 8 bits) and the parity mode (none, even or odd). The block latches that format when the start edge is found.

Each completed character leaves the block as one push on a single-entry output. The push carries the byte, a three-bit error tag and a one-cycle valid strobe. If the sink is not ready at that moment, the character is dropped and an overrun pulse is given instead. A line held low for a whole character produces exactly one break character. The receiver then waits for the line to return high before it arms again.

The controller has six states: IDLE, START, DATA, PARITY, STOP and HOLD. The transitions are:

- start-seen: IDLE to START, when a tick samples the line low.
- false-start: START to IDLE, when the mid-bit sample of the start bit is high.
- start-ok: START to DATA, at the end of the start bit.
- data-done: DATA to PARITY or STOP, after the last data bit.
- parity-done: PARITY to STOP.
- stop-done: STOP to IDLE, at the stop-bit vote.
- break-seen: STOP to HOLD, when every sample since the start was low.
- line-high: HOLD to IDLE, when a tick sees the line high.

Top module: `serial_rx_tag`

## Requirements
- R1: `cfg_len` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits arrive least significant first. For shorter lengths, `out_data` bits above the length are zero.
- R2: With `cfg_par_en`=1, one parity bit follows the data. Even parity (`cfg_par_odd`=0) expects an even count of ones over data plus parity. Odd parity expects an odd count. A mismatch sets `out_err[2]`. With parity off, `out_err[2]` is 0.
- R3: Each data, parity and stop bit takes the majority of samples 7, 8 and 9 of its sixteen. One wrong sample among them does not change the result.
- R4: A start bit that reads high at its sample 8 is discarded. The receiver goes back to IDLE, and neither `out_valid` nor `rx_overrun` pulses.
- R5: A first stop bit voted low sets `out_err[1]` (framing). Only the first stop bit is examined.
- R6: A line that stays low through the start, data, parity and stop bits gives exactly one character. Its data is 0 and `out_err` is 3'b001. No further character comes until the line has been high.
- R7: `out_valid` is a single-cycle pulse. It rises in the clock cycle after the tick that takes sample 9 of the first stop bit.
- R8: If `out_ready` is low when a character completes, that character is dropped, `out_valid` stays low and `rx_overrun` pulses for one cycle.
- R9: After reset `out_valid` and `rx_overrun` are low, and the receiver waits idle for a start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | One-cycle enable at 16x the bit rate |
| rxd | input | 1 | Serial line, idle high |
| cfg_len | input | 2 | Data length code (length = 5 + code) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| out_ready | input | 1 | Sink can accept a character |
| out_valid | output | 1 | One-cycle strobe for a new character |
| out_data | output | 8 | Received character, zero-extended |
| out_err | output | 3 | Tag: [2] parity, [1] framing, [0] break |
| rx_overrun | output | 1 | One-cycle pulse when a character is dropped |

## Verification
The line passes through a two-flop synchronizer, so a level driven just before a tick edge is seen at the next tick, four clocks later. The character result is due in the cycle after the ninth tick of the stop bit: 37 clocks after the bench drives that bit. The bench stamps each strobe with a cycle count and compares it against exactly that offset. Characters that are dropped (false starts) or swallowed (overrun) are checked only after enough further bit periods that any result would already have appeared.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

    localparam int CHAR_W = 8;
    localparam int ERR_W  = 3;

    localparam int ERR_PAR = 2;
    localparam int ERR_FRM = 1;
    localparam int ERR_BRK = 0;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4,
        ST_HOLD   = 3'd5
    } rx_state_t;

endpackage

// File: rtl/rxc_sync.sv
module rxc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], din};
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/rxc_voter.sv
module rxc_voter (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_en,
    input  logic din,
    output logic vote
);

    logic [1:0] held;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held <= 2'b11;
        end else if (cap_en) begin
            held <= {held[0], din};
        end
    end

    assign vote = (held[1] & held[0]) | (held[1] & din) | (held[0] & din);

endmodule

// File: rtl/rxc_fsm.sv
module rxc_fsm
    import rxc_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               os_tick,
    input  logic               rx,
    input  logic               vote,
    input  logic [1:0]         cfg_len,
    input  logic               cfg_par_en,
    input  logic               cfg_par_odd,
    input  logic               out_ready,
    output logic               cap_en,
    output logic               out_valid,
    output logic [CHAR_W-1:0]  out_data,
    output logic [ERR_W-1:0]   out_err,
    output logic               rx_overrun
);

    localparam int CW = $clog2(OVS) + 1;
    localparam logic [CW-1:0] S_LAST = CW'(OVS);
    localparam logic [CW-1:0] S_MID  = CW'(OVS / 2);
    localparam logic [CW-1:0] S_PRE  = CW'(OVS / 2 - 1);
    localparam logic [CW-1:0] S_POST = CW'(OVS / 2 + 1);

    rx_state_t         state, state_nx;
    logic [CW-1:0]     cnt;
    logic [CW-1:0]     s;
    logic [2:0]        bit_idx;
    logic [1:0]        len_q;
    logic              pen_q;
    logic              podd_q;
    logic [CHAR_W-1:0] shreg;
    logic              par_acc;
    logic              par_bad;
    logic              all_zero;
    logic [2:0]        last_idx;
    logic              at_vote;
    logic              at_end;
    logic              brk;

    assign s        = cnt + CW'(1);
    assign last_idx = {1'b1, len_q};
    assign at_vote  = os_tick && (s == S_POST);
    assign at_end   = os_tick && (s == S_LAST);
    assign cap_en   = os_tick && ((s == S_PRE) || (s == S_MID));
    assign brk      = all_zero && !vote;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (os_tick && !rx) state_nx = ST_START;            // start-seen
            end
            ST_START: begin
                if (os_tick && (s == S_MID) && rx) state_nx = ST_IDLE; // false-start
                else if (at_end) state_nx = ST_DATA;                  // start-ok
            end
            ST_DATA: begin
                if (at_end && (bit_idx == last_idx))
                    state_nx = pen_q ? ST_PARITY : ST_STOP;          // data-done
            end
            ST_PARITY: begin
                if (at_end) state_nx = ST_STOP;                      // parity-done
            end
            ST_STOP: begin
                if (at_vote) state_nx = brk ? ST_HOLD : ST_IDLE;     // break-seen / stop-done
            end
            ST_HOLD: begin
                if (os_tick && rx) state_nx = ST_IDLE;               // line-high
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            bit_idx    <= '0;
            len_q      <= '0;
            pen_q      <= 1'b0;
            podd_q     <= 1'b0;
            shreg      <= '0;
            par_acc    <= 1'b0;
            par_bad    <= 1'b0;
            all_zero   <= 1'b0;
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_err    <= '0;
            rx_overrun <= 1'b0;
        end else begin
            out_valid  <= 1'b0;
            rx_overrun <= 1'b0;
            if (os_tick) begin
                if (state == ST_IDLE) begin
                    if (!rx) begin
                        cnt      <= CW'(1);
                        bit_idx  <= '0;
                        len_q    <= cfg_len;
                        pen_q    <= cfg_par_en;
                        podd_q   <= cfg_par_odd;
                        shreg    <= '0;
                        par_acc  <= 1'b0;
                        par_bad  <= 1'b0;
                        all_zero <= 1'b1;
                    end
                end else begin
                    cnt <= (s == S_LAST) ? '0 : s;
                end
            end
            unique case (state)
                ST_DATA: begin
                    if (at_vote) begin
                        shreg[bit_idx] <= vote;
                        par_acc        <= par_acc ^ vote;
                        if (vote) all_zero <= 1'b0;
                    end
                    if (at_end && (bit_idx != last_idx)) bit_idx <= bit_idx + 3'd1;
                end
                ST_PARITY: begin
                    if (at_vote) begin
                        par_bad <= par_acc ^ vote ^ podd_q;
                        if (vote) all_zero <= 1'b0;
                    end
                end
                ST_STOP: begin
                    if (at_vote) begin
                        if (out_ready) begin
                            out_valid <= 1'b1;
                            if (brk) begin
                                out_data <= '0;
                                out_err  <= ERR_W'(1) << ERR_BRK;
                            end else begin
                                out_data          <= shreg;
                                out_err           <= '0;
                                out_err[ERR_PAR]  <= pen_q && par_bad;
                                out_err[ERR_FRM]  <= !vote;
                            end
                        end else begin
                            rx_overrun <= 1'b1;
                        end
                    end
                end
                ST_IDLE, ST_START, ST_HOLD: begin
                end
                default: begin
                end
            endcase
        end
    end

    // R4: a high mid-sample of the start bit returns to idle without output
    p_false_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_START && os_tick && s == S_MID && rx) |=> (state == ST_IDLE && !out_valid && !rx_overrun));

    // R7: the strobe never lasts more than one cycle
    p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R8: a character is either delivered or dropped, never both
    p_drop_or_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && rx_overrun));

    // R6: a break character carries no data and only the break tag
    p_break_tag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_err[ERR_BRK]) |-> (out_data == '0 && !out_err[ERR_PAR] && !out_err[ERR_FRM]));

    // R1: five-bit characters leave the upper bits clear
    p_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && len_q == 2'd0) |-> (out_data[7:5] == 3'b000));

    // R2: no parity error without parity
    p_par_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !pen_q) |-> !out_err[ERR_PAR]);

endmodule

// File: rtl/serial_rx_tag.sv
module serial_rx_tag
    import rxc_pkg::*;
#(
    parameter int OVS       = 16,
    parameter int SYNC_FLOP = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        os_tick,
    input  logic        rxd,
    input  logic [1:0]  cfg_len,
    input  logic        cfg_par_en,
    input  logic        cfg_par_odd,
    input  logic        out_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    output logic [2:0]  out_err,
    output logic        rx_overrun
);

    logic rx_s;
    logic vote;
    logic cap_en;

    rxc_sync #(.STAGES(SYNC_FLOP)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .dout  (rx_s)
    );

    rxc_voter u_voter (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .din    (rx_s),
        .vote   (vote)
    );

    rxc_fsm #(.OVS(OVS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .os_tick     (os_tick),
        .rx          (rx_s),
        .vote        (vote),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .out_ready   (out_ready),
        .cap_en      (cap_en),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_err     (out_err),
        .rx_overrun  (rx_overrun)
    );

endmodule

// File: tb/serial_rx_tag_bench.sv
`timescale 1ns/100ps
module serial_rx_tag_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic [1:0] tdiv = 2'd0;
    logic       rxd = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       out_ready = 1'b1;
    logic       out_valid;
    logic [7:0] out_data;
    logic [2:0] out_err;
    logic       rx_overrun;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int vcnt = 0;
    int ocnt = 0;
    int wide = 0;
    int l_cyc = 0;
    int c_stop = 0;
    logic [7:0] l_data = 8'd0;
    logic [2:0] l_err = 3'd0;
    bit pv = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        tdiv    <= tdiv + 2'd1;
        os_tick <= (tdiv == 2'd3);
    end

    serial_rx_tag u_serial_rx_tag (
        .clk         (clk),
        .rst_n       (rst_n),
        .os_tick     (os_tick),
        .rxd         (rxd),
        .cfg_len     (cfg_len),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .out_ready   (out_ready),
        .out_valid   (out_valid),
        .out_data    (out_data),
        .out_err     (out_err),
        .rx_overrun  (rx_overrun)
    );

    always @(negedge clk) begin
        if (out_valid) begin
            vcnt   = vcnt + 1;
            l_data = out_data;
            l_err  = out_err;
            l_cyc  = cyc;
            if (pv) wide = wide + 1;
        end
        if (rx_overrun) ocnt = ocnt + 1;
        pv = out_valid;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (os_tick !== 1'b1);
    endtask

    task automatic send_bit(input bit v, input bit gl);
        rxd = v;
        if (gl) begin
            repeat (7) wait_tick();
            rxd = ~v;
            wait_tick();
            rxd = v;
            repeat (8) wait_tick();
        end else begin
            repeat (16) wait_tick();
        end
    endtask

    function automatic logic [7:0] len_mask(input logic [1:0] len);
        return 8'hFF >> (3 - len);
    endfunction

    function automatic logic [10:0] expect_char(input logic [7:0] d, input logic [1:0] len,
                                                input bit pe, input bit po, input bit badp, input bit bads);
        logic [7:0] dm;
        logic       p;
        bit         brk;
        dm  = d & len_mask(len);
        p   = (^dm) ^ po ^ badp;
        brk = (dm == 8'd0) && (!pe || !p) && bads;
        if (brk) return {3'b001, 8'd0};
        return {pe & badp, bads, 1'b0, dm};
    endfunction

    task automatic send_frame(input logic [7:0] d, input logic [1:0] len, input bit pe, input bit po,
                              input bit badp, input bit bads, input int gl_bit);
        logic [7:0] dm;
        dm          = d & len_mask(len);
        cfg_len     = len;
        cfg_par_en  = pe;
        cfg_par_odd = po;
        send_bit(1'b0, 1'b0);
        for (int i = 0; i < 5 + int'(len); i++) send_bit(d[i], gl_bit == i);
        if (pe) send_bit((^dm) ^ po ^ badp, 1'b0);
        c_stop = cyc;
        send_bit(!bads, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
    endtask

    task automatic run_check(input logic [7:0] d, input logic [1:0] len, input bit pe, input bit po,
                             input bit badp, input bit bads, input int gl_bit, input string tag);
        int v0;
        logic [10:0] e;
        v0 = vcnt;
        e  = expect_char(d, len, pe, po, badp, bads);
        send_frame(d, len, pe, po, badp, bads, gl_bit);
        chk(vcnt == v0 + 1, {tag, " R7 one char"}, vcnt - v0, 1);
        chk(l_data == e[7:0], {tag, " data"}, l_data, e[7:0]);
        chk(l_err == e[10:8], {tag, " err"}, l_err, e[10:8]);
        chk(l_cyc == c_stop + 37, {tag, " R7 timing"}, l_cyc - c_stop, 37);
    endtask

    task automatic false_start(input int n, input string tag);
        int v0;
        int o0;
        v0  = vcnt;
        o0  = ocnt;
        rxd = 1'b0;
        repeat (n) wait_tick();
        rxd = 1'b1;
        repeat (48) wait_tick();
        chk(vcnt == v0, {tag, " no char"}, vcnt - v0, 0);
        chk(ocnt == o0, {tag, " no overrun"}, ocnt - o0, 0);
    endtask

    initial begin
        int v0;
        int o0;
        void'($urandom(32'd24681));
        repeat (5) @(negedge clk);
        chk(out_valid == 1'b0, "R9 valid after reset", out_valid, 0);
        chk(rx_overrun == 1'b0, "R9 overrun after reset", rx_overrun, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        wait_tick();
        repeat (16) wait_tick();
        chk(vcnt == 0, "R9 idle line gives nothing", vcnt, 0);

        run_check(8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R1 eight bits");
        run_check(8'hFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R1 five bits");
        run_check(8'hC6, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R1 six bits");
        run_check(8'h6B, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R1 seven bits");
        run_check(8'h3D, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, -1, "R2 even ok");
        run_check(8'h3D, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0, -1, "R2 odd ok");
        run_check(8'h3D, 2'd3, 1'b1, 1'b0, 1'b1, 1'b0, -1, "R2 even bad");
        run_check(8'h12, 2'd2, 1'b1, 1'b1, 1'b1, 1'b0, -1, "R2 odd bad");
        run_check(8'h55, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 3, "R3 glitch on one");
        run_check(8'h55, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 4, "R3 glitch on zero");
        run_check(8'h81, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, -1, "R5 framing");
        run_check(8'h81, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1, -1, "R5 framing with parity");

        false_start(5, "R4 short low");
        false_start(1, "R4 one sample low");
        run_check(8'h9E, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R4 recovery");

        // R6 break: low well past one character, then high
        v0          = vcnt;
        cfg_len     = 2'd3;
        cfg_par_en  = 1'b1;
        cfg_par_odd = 1'b1;
        rxd         = 1'b0;
        repeat (14 * 16) wait_tick();
        rxd = 1'b1;
        repeat (32) wait_tick();
        chk(vcnt == v0 + 1, "R6 single break char", vcnt - v0, 1);
        chk(l_data == 8'd0, "R6 break data", l_data, 0);
        chk(l_err == 3'b001, "R6 break tag", l_err, 1);
        run_check(8'h5A, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R6 recovery");

        // R8 overrun
        v0        = vcnt;
        o0        = ocnt;
        out_ready = 1'b0;
        send_frame(8'h77, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, -1);
        out_ready = 1'b1;
        chk(vcnt == v0, "R8 dropped char", vcnt - v0, 0);
        chk(ocnt == o0 + 1, "R8 overrun pulse", ocnt - o0, 1);
        o0 = ocnt;
        run_check(8'h2C, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, -1, "R8 after drop");
        chk(ocnt == o0, "R8 no overrun when ready", ocnt - o0, 0);

        for (int k = 0; k < 60; k++) begin
            logic [7:0] d;
            logic [1:0] len;
            bit pe;
            bit po;
            bit badp;
            bit bads;
            int gl;
            d    = 8'($urandom);
            len  = 2'($urandom % 4);
            pe   = 1'($urandom % 2);
            po   = 1'($urandom % 2);
            badp = pe && ($urandom % 8 == 0);
            bads = ($urandom % 8 == 0);
            gl   = ($urandom % 4 == 0) ? int'($urandom % (5 + int'(len))) : -1;
            run_check(d, len, pe, po, badp, bads, gl, "R1/R2/R3/R5 random");
        end

        chk(wide == 0, "R7 pulse width", wide, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        done = 1'b1;
        $finish;
    end

    initial begin
        #950000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule